// File: doc/BRIEF.md
# Motor Drive Overcurrent Protection Gate

This block sits between the six-signal PWM polarity stage and the gate-drive pins of a three-phase bridge. Two current-sensing paths can take over the drive pins. An overcurrent comparator output enters raw and asynchronous, passes through a synchronizer and an edge detector, and can latch a protect flag. While that flag is set, a programmable safe pattern replaces the PWM signals. A current-limit event arrives as a synchronous one-cycle pulse. It turns all six drive signals off until software clears it. Software can then choose to wait for the next PWM period before the signals are released.

Control comes from register-style inputs. Each path has its own hardware enable. Other inputs choose the comparator edge, pick between a latching fault response and a level-following pause response, and choose the restart policy after a limit event. A 0-to-1 transition on the protection-enable bit re-arms the latch. Every accepted event produces a one-cycle interrupt pulse. All outputs are registered.

Top module: `mdrv_ocp_gate`

## Requirements
- R1: A synchronous reset drives `drv_out` to all zeros and clears `prot_flag`, `oc_irq` and `lim_irq`. The re-arm edge detector also resets, with its previous-value register set to 0.
- R2: When no protection or limit condition is active, `drv_out` equals `pwm_in` as sampled on the previous rising clock edge.
- R3: `oc_cmp` passes through two synchronizing flops before edge detection. An edge on `oc_cmp` is reported on the third rising clock edge after the change. The edge code values are: 0 for a rising edge, 1 for a falling edge, 2 for both edges and 3 for both edges as interrupt only. `oc_irq` is high for exactly one cycle for each detected edge, whatever the enable and mode settings.
- R4: An overcurrent edge trips the block when `oc_hw_en`=1, `oc_mode`=0 (fault) and the edge code is not 3. On the same edge as `oc_irq`, `prot_flag` goes to 1 and `drv_out` takes the value of `safe_pat`.
- R5: Once set, `prot_flag` stays at 1 after the comparator returns low. It clears only on a clock edge where `prot_en` is 1 and was 0 on the previous edge. Pass-through resumes on that same edge. If a trip and a re-arm fall on the same edge, the trip wins.
- R6: Edge code 3 produces `oc_irq` pulses but never sets `prot_flag` and never overrides `drv_out`.
- R7: When `oc_hw_en`=0, overcurrent edges neither set `prot_flag` nor override `drv_out`.
- R8: Pause mode applies when `oc_mode`=1, `oc_hw_en`=1 and the edge code is not 3. In this mode `drv_out` equals `safe_pat` while the synchronized comparator is high. No latch is set. Pass-through returns on the edge after the synchronized comparator falls.
- R9: When `lim_hw_en`=1, a `lim_evt` pulse forces `drv_out` to all zeros on the edge that samples it. The zeros hold until a clear arrives. `lim_irq` pulses for one cycle on that same edge.
- R10: When `lim_restart_sel`=0, `drv_out` is released on the edge that samples `lim_irq_clr`.
- R11: When `lim_restart_sel`=1, the outputs stay at zero after the clear until a `period_start` is sampled on a later edge. A `period_start` on the same edge as the clear is ignored. Release happens on the edge that samples the accepted `period_start`.
- R12: When `lim_hw_en`=0, `lim_evt` does not change `drv_out`. `lim_irq` still pulses.
- R13: While both a protect or pause condition and a limit condition are active, `drv_out` shows `safe_pat` rather than zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 6 | Drive signals from the PWM polarity stage |
| oc_cmp | input | 1 | Raw asynchronous overcurrent comparator output |
| oc_hw_en | input | 1 | Overcurrent hardware path enable |
| oc_edge_sel | input | 2 | Edge code: 0 rise, 1 fall, 2 both, 3 interrupt only |
| oc_mode | input | 1 | 0 selects fault (latch), 1 selects pause |
| prot_en | input | 1 | Protection enable; a 0-to-1 transition re-arms the latch |
| safe_pat | input | 6 | Drive pattern used while protection is active |
| lim_evt | input | 1 | Synchronous current-limit event pulse |
| lim_hw_en | input | 1 | Current-limit hardware path enable |
| lim_irq_clr | input | 1 | Software clear of the pending current-limit interrupt |
| lim_restart_sel | input | 1 | 0 releases at once, 1 waits for the next PWM period |
| period_start | input | 1 | Strobe from the PWM timer at each new period |
| drv_out | output | 6 | Gated drive signals |
| oc_irq | output | 1 | One-cycle overcurrent interrupt pulse |
| lim_irq | output | 1 | One-cycle current-limit interrupt pulse |
| prot_flag | output | 1 | Latched overcurrent protect status |

## Verification
Directed sequences use a single comparator pulse under each edge code. A rising-only code tells a latch set on entry apart from one set on exit. Code 3 and the cleared hardware enable separate interrupt generation from protection. Pause mode shows level-following behaviour rather than latching. The current-limit sequences place a clear alone, a clear with a coincident period strobe, and a later strobe. These separate immediate release, ignored strobes and deferred release. A long random run then overlaps both paths, re-arms and mode changes, and compares every output each cycle against a bench model built from the requirements.

// File: rtl/mdrv_ocp_pkg.sv
package mdrv_ocp_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE     = 2'b00,
    EDGE_FALL     = 2'b01,
    EDGE_BOTH     = 2'b10,
    EDGE_IRQ_ONLY = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/ocp_edge_detect.sv
module ocp_edge_detect
  import mdrv_ocp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmp_raw,
  input  edge_sel_e edge_sel,
  output logic      cmp_sync,
  output logic      evt
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic               cmp_prev;
  logic               rise_w, fall_w;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN_W-2:0], cmp_raw};
  end

  assign cmp_sync = chain_q[SYNC_STAGES-1];
  assign cmp_prev = chain_q[SYNC_STAGES];
  assign rise_w   = cmp_sync & ~cmp_prev;
  assign fall_w   = ~cmp_sync & cmp_prev;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: evt = rise_w;
      EDGE_FALL: evt = fall_w;
      default:   evt = rise_w | fall_w;
    endcase
  end
endmodule

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch
  import mdrv_ocp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      evt,
  input  logic      cmp_sync,
  input  edge_sel_e edge_sel,
  input  logic      hw_en,
  input  logic      pause_mode,
  input  logic      prot_en,
  output logic      flag_nxt,
  output logic      flag_q,
  output logic      pause_act,
  output logic      irq_q
);
  logic en_prev_q;
  logic en_rise;
  logic path_live;
  logic trip;

  assign en_rise   = prot_en & ~en_prev_q;
  assign path_live = hw_en & (edge_sel != EDGE_IRQ_ONLY);
  assign trip      = evt & path_live & ~pause_mode;
  assign flag_nxt  = trip | (flag_q & ~en_rise);
  assign pause_act = path_live & pause_mode & cmp_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev_q <= 1'b0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      en_prev_q <= prot_en;
      flag_q    <= flag_nxt;
      irq_q     <= evt;
    end
  end

  assert_rearm_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(en_rise));
  assert_irq_only_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> ($past(edge_sel) != EDGE_IRQ_ONLY));
  assert_hw_off_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(hw_en));
endmodule

// File: rtl/ilim_restart.sv
module ilim_restart (
  input  logic clk,
  input  logic rst,
  input  logic lim_evt,
  input  logic lim_clr,
  input  logic period_start,
  input  logic restart_sel,
  input  logic hw_en,
  output logic block_nxt,
  output logic irq_q
);
  logic pend_q, wait_q;
  logic pend_nxt, wait_nxt;

  assign pend_nxt  = lim_evt | (pend_q & ~lim_clr);
  assign wait_nxt  = (lim_clr & pend_q & restart_sel & ~lim_evt)
                   | (wait_q & ~period_start);
  assign block_nxt = hw_en & (pend_nxt | wait_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      wait_q <= wait_nxt;
      irq_q  <= lim_evt;
    end
  end

  assert_lim_irq_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(lim_evt));
  assert_wait_release_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_q) |-> $past(period_start));
endmodule

// File: rtl/drive_gate.sv
module drive_gate #(
  parameter int NUM_OUT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] pwm_in,
  input  logic [NUM_OUT-1:0] safe_pat,
  input  logic               force_safe,
  input  logic               force_off,
  output logic [NUM_OUT-1:0] drv_out
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)             drv_out[i] <= 1'b0;
      else if (force_safe) drv_out[i] <= safe_pat[i];
      else if (force_off)  drv_out[i] <= 1'b0;
      else                 drv_out[i] <= pwm_in[i];
    end
  end
endmodule

// File: rtl/mdrv_ocp_gate.sv
module mdrv_ocp_gate
  import mdrv_ocp_pkg::*;
#(
  parameter int NUM_OUT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] pwm_in,
  input  logic               oc_cmp,
  input  logic               oc_hw_en,
  input  logic [1:0]         oc_edge_sel,
  input  logic               oc_mode,
  input  logic               prot_en,
  input  logic [NUM_OUT-1:0] safe_pat,
  input  logic               lim_evt,
  input  logic               lim_hw_en,
  input  logic               lim_irq_clr,
  input  logic               lim_restart_sel,
  input  logic               period_start,
  output logic [NUM_OUT-1:0] drv_out,
  output logic               oc_irq,
  output logic               lim_irq,
  output logic               prot_flag
);
  edge_sel_e sel;
  logic cmp_sync, oc_evt, flag_nxt, pause_act, block_nxt;

  assign sel = edge_sel_e'(oc_edge_sel);

  ocp_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .cmp_raw(oc_cmp), .edge_sel(sel),
    .cmp_sync(cmp_sync), .evt(oc_evt)
  );

  ocp_trip_latch u_trip (
    .clk(clk), .rst(rst), .evt(oc_evt), .cmp_sync(cmp_sync),
    .edge_sel(sel), .hw_en(oc_hw_en), .pause_mode(oc_mode),
    .prot_en(prot_en), .flag_nxt(flag_nxt), .flag_q(prot_flag),
    .pause_act(pause_act), .irq_q(oc_irq)
  );

  ilim_restart u_lim (
    .clk(clk), .rst(rst), .lim_evt(lim_evt), .lim_clr(lim_irq_clr),
    .period_start(period_start), .restart_sel(lim_restart_sel),
    .hw_en(lim_hw_en), .block_nxt(block_nxt), .irq_q(lim_irq)
  );

  drive_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .safe_pat(safe_pat),
    .force_safe(flag_nxt | pause_act), .force_off(block_nxt),
    .drv_out(drv_out)
  );

  assert_safe_hold_R4: assert property (@(posedge clk) disable iff (rst)
    prot_flag |-> (drv_out == $past(safe_pat)));
endmodule

// File: tb/mdrv_ocp_gate_tb.sv
module mdrv_ocp_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic [NOUT-1:0] pwm_in = '0, safe_pat = '0;
  logic oc_cmp = 0, oc_hw_en = 0, oc_mode = 0, prot_en = 0;
  logic [1:0] oc_edge_sel = 2'd0;
  logic lim_evt = 0, lim_hw_en = 0, lim_irq_clr = 0, lim_restart_sel = 0, period_start = 0;
  logic [NOUT-1:0] drv_out;
  logic oc_irq, lim_irq, prot_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  mdrv_ocp_gate u_dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .oc_cmp(oc_cmp), .oc_hw_en(oc_hw_en),
    .oc_edge_sel(oc_edge_sel), .oc_mode(oc_mode), .prot_en(prot_en),
    .safe_pat(safe_pat), .lim_evt(lim_evt), .lim_hw_en(lim_hw_en),
    .lim_irq_clr(lim_irq_clr), .lim_restart_sel(lim_restart_sel),
    .period_start(period_start), .drv_out(drv_out), .oc_irq(oc_irq),
    .lim_irq(lim_irq), .prot_flag(prot_flag)
  );

  // Bench model state, written from the requirements
  logic m_s1, m_s2, m_s3, m_pen, m_flag, m_pend, m_wait;
  logic [NOUT-1:0] e_drv;
  logic e_oc_irq, e_lim_irq;

  function automatic logic edge_hit(logic [1:0] code, logic now, logic prev);
    case (code)
      2'd0:    return now & ~prev;
      2'd1:    return ~now & prev;
      default: return now ^ prev;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_s1, m_s2, m_s3, m_pen, m_flag, m_pend, m_wait} = '0;
      e_drv = '0; e_oc_irq = 0; e_lim_irq = 0;
    end else begin
      logic det, live, nflag, pause, npend, nwait, blk;
      det   = edge_hit(oc_edge_sel, m_s2, m_s3);
      live  = oc_hw_en && oc_edge_sel != 2'd3;
      nflag = (det & live & ~oc_mode) | (m_flag & ~(prot_en & ~m_pen));
      pause = live & oc_mode & m_s2;
      npend = lim_evt | (m_pend & ~lim_irq_clr);
      nwait = (lim_irq_clr & m_pend & lim_restart_sel & ~lim_evt) | (m_wait & ~period_start);
      blk   = lim_hw_en & (npend | nwait);
      e_drv = (nflag | pause) ? safe_pat : (blk ? '0 : pwm_in);
      e_oc_irq = det; e_lim_irq = lim_evt;
      m_flag = nflag; m_pend = npend; m_wait = nwait; m_pen = prot_en;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = oc_cmp;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk(tag, "drv_out", 32'(drv_out), 32'(e_drv));
    chk(tag, "oc_irq", 32'(oc_irq), 32'(e_oc_irq));
    chk(tag, "lim_irq", 32'(lim_irq), 32'(e_lim_irq));
    chk(tag, "prot_flag", 32'(prot_flag), 32'(m_flag));
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    prot_en = 0; step(1); prot_en = 1; step(2);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    step(3);
    chk("R1", "reset drv_out", 32'(drv_out), 0);
    chk("R1", "reset prot_flag", 32'(prot_flag), 0);
    chk("R1", "reset irqs", {oc_irq, lim_irq}, 0);
    rst = 0;
    tag = "R2";
    for (int i = 0; i < 20; i++) begin pwm_in = NOUT'($urandom); step(1); end
    pwm_in = 6'h15; step(1);
    chk("R2", "pass-through", 32'(drv_out), 32'h15);

    tag = "R4"; safe_pat = 6'h2A; oc_hw_en = 1; oc_mode = 0; oc_edge_sel = 2'd0;
    oc_cmp = 1; step(4);
    chk("R4", "trip flag", 32'(prot_flag), 1);
    chk("R4", "safe pattern", 32'(drv_out), 32'h2A);
    tag = "R5"; oc_cmp = 0; step(5);
    chk("R5", "flag held", 32'(prot_flag), 1);
    rearm();
    chk("R5", "flag cleared", 32'(prot_flag), 0);
    chk("R5", "pass resumed", 32'(drv_out), 32'h15);

    tag = "R3"; oc_edge_sel = 2'd1; oc_cmp = 1; step(4);
    chk("R3", "rise ignored on fall code", 32'(prot_flag), 0);
    oc_cmp = 0; step(4);
    chk("R3", "fall trips", 32'(prot_flag), 1);
    rearm();

    tag = "R6"; oc_edge_sel = 2'd3; oc_cmp = 1; step(4); oc_cmp = 0; step(4);
    chk("R6", "irq-only no flag", 32'(prot_flag), 0);
    chk("R6", "irq-only no override", 32'(drv_out), 32'h15);

    tag = "R7"; oc_edge_sel = 2'd0; oc_hw_en = 0; oc_cmp = 1; step(4); oc_cmp = 0; step(4);
    chk("R7", "disabled no flag", 32'(prot_flag), 0);

    tag = "R8"; oc_hw_en = 1; oc_mode = 1; oc_cmp = 1; step(4);
    chk("R8", "pause safe", 32'(drv_out), 32'h2A);
    chk("R8", "pause no latch", 32'(prot_flag), 0);
    oc_cmp = 0; step(3);
    chk("R8", "pause recovered", 32'(drv_out), 32'h15);

    tag = "R9"; lim_hw_en = 1; lim_restart_sel = 0;
    lim_evt = 1; step(1); lim_evt = 0; step(3);
    chk("R9", "limit off", 32'(drv_out), 0);
    tag = "R10"; lim_irq_clr = 1; step(1); lim_irq_clr = 0;
    chk("R10", "immediate release", 32'(drv_out), 32'h15);

    tag = "R11"; lim_restart_sel = 1; lim_evt = 1; step(1); lim_evt = 0; step(1);
    lim_irq_clr = 1; period_start = 1; step(1); lim_irq_clr = 0; period_start = 0;
    chk("R11", "coincident strobe ignored", 32'(drv_out), 0);
    step(3);
    chk("R11", "still waiting", 32'(drv_out), 0);
    period_start = 1; step(1); period_start = 0;
    chk("R11", "released at period", 32'(drv_out), 32'h15);

    tag = "R12"; lim_hw_en = 0; lim_evt = 1; step(1); lim_evt = 0;
    chk("R12", "limit disabled", 32'(drv_out), 32'h15);
    lim_irq_clr = 1; step(1); lim_irq_clr = 0;

    tag = "R13"; lim_hw_en = 1; oc_mode = 0; lim_evt = 1; step(1); lim_evt = 0;
    oc_cmp = 1; step(4);
    chk("R13", "safe over off", 32'(drv_out), 32'h2A);
    oc_cmp = 0; lim_irq_clr = 1; step(1); lim_irq_clr = 0; rearm();

    for (int i = 0; i < 4000; i++) begin
      pwm_in = NOUT'($urandom);
      if ($urandom_range(9) == 0) oc_cmp = ~oc_cmp;
      lim_evt = ($urandom_range(15) == 0);
      lim_irq_clr = ($urandom_range(7) == 0);
      period_start = ($urandom_range(7) == 0);
      if ($urandom_range(3) == 0) prot_en = ~prot_en;
      if ($urandom_range(49) == 0) begin
        oc_edge_sel = 2'($urandom); oc_mode = 1'($urandom); oc_hw_en = 1'($urandom);
        lim_hw_en = 1'($urandom); lim_restart_sel = 1'($urandom); safe_pat = NOUT'($urandom);
      end
      step(1);
    end
    finish_run();
  end
endmodule